// File: doc/BRIEF.md
# One-Hot Power-of-Two Clock Enable Divider

The block turns a stream of source ticks into a slower stream of single-cycle clock-enable pulses. Downstream CPU and peripheral logic uses these pulses as the enable for the system clock. Everything runs on one clock.

There are two tick sources. A select input picks one of them: the PLL tick when the select is low, the external tick when it is high. A 32-bit control word sets the division.

- Its low 16 bits are a one-hot divide field. With bit n set, one enable pulse is issued for every 2^n selected ticks.
- With the field all zero, every selected tick is passed through. This is also the reset state.
- When more than one bit is set, the lowest set bit decides the ratio.

A newly written ratio is taken into use only at the end of the current divided period. The output therefore never shows a shortened period.

Top module: `onehot_clkdiv`

## Requirements
- R1: After reset the control word reads 0x00000000 and the output pulses once for every selected tick.
- R2: With divide field bits [15:0] all zero, en_o is high in the cycle after each selected tick and low otherwise.
- R3: With only bit n of the divide field set, en_o pulses once per 2^n selected ticks, whether ticks arrive every cycle or sparsely; n=15 gives 32768.
- R4: With several divide bits set, the lowest set bit alone sets the ratio.
- R5: src_sel_i low counts pll_tick_i and ignores ext_tick_i; src_sel_i high counts ext_tick_i and ignores pll_tick_i.
- R6: A new ratio takes effect only at the end of the current period. The next pulse after a write keeps the old spacing, and later pulses use the new one.
- R7: rd_data_o returns bits [15:0] and bit 31 as last written; bits [30:16] read as zero; bit 31 has no effect on division.
- R8: The internal period count never exceeds the active ratio minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_sel_i | input | 1 | 0 selects PLL ticks, 1 selects external ticks |
| pll_tick_i | input | 1 | Tick from the PLL source |
| ext_tick_i | input | 1 | Tick from the external source |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 32 | Control word write data |
| rd_data_o | output | 32 | Control word readback |
| en_o | output | 1 | Divided clock-enable pulse |

## Verification
A write is latched at the clock edge that samples wr_en_i, so the readback is checked at the next falling edge. An enable pulse appears in the cycle after the edge that samples the tick that ends a period. The bench therefore sets the ticks at one falling edge and compares en_o at the next falling edge, and it measures pulse spacing by counting falling edges between pulses. After a ratio write, the bench first lets the pulse at the old boundary pass and only then measures. The old boundary pulse is itself checked against the old spacing.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int unsigned DIV_W  = 16;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned TEST_B = 31;
  localparam int unsigned SH_W   = $clog2(DIV_W);
  localparam int unsigned CNT_W  = (DIV_W > 1) ? DIV_W - 1 : 1;

  typedef logic [SH_W-1:0]  shift_t;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/clkdiv_ctrl_reg.sv
module clkdiv_ctrl_reg
  import clkdiv_pkg::*;
#(
  parameter int unsigned REG_W_P  = REG_W,
  parameter int unsigned DIV_W_P  = DIV_W,
  parameter int unsigned TEST_B_P = TEST_B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [REG_W_P-1:0] wr_data_i,
  output logic [DIV_W_P-1:0] div_field_o,
  output logic [REG_W_P-1:0] rd_data_o
);
  logic [DIV_W_P-1:0] div_q;
  logic               test_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      test_q <= 1'b0;
    end else if (wr_en_i) begin
      div_q  <= wr_data_i[DIV_W_P-1:0];
      test_q <= wr_data_i[TEST_B_P];
    end
  end

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[DIV_W_P-1:0]    = div_q;
    rd_data_o[TEST_B_P]       = test_q;
  end

  assign div_field_o = div_q;
endmodule

// File: rtl/clkdiv_ratio_dec.sv
module clkdiv_ratio_dec
  import clkdiv_pkg::*;
#(
  parameter int unsigned DIV_W_P = DIV_W,
  parameter int unsigned SH_W_P  = SH_W
) (
  input  logic [DIV_W_P-1:0] div_field_i,
  output logic [SH_W_P-1:0]  shift_o
);
  // lowest set bit wins; empty field maps to shift 0 (pass-through)
  always_comb begin
    shift_o = '0;
    for (int i = DIV_W_P - 1; i >= 0; i--) begin
      if (div_field_i[i]) shift_o = SH_W_P'(i);
    end
  end
endmodule

// File: rtl/clkdiv_tick_gen.sv
module clkdiv_tick_gen
  import clkdiv_pkg::*;
#(
  parameter int unsigned SH_W_P  = SH_W,
  parameter int unsigned CNT_W_P = CNT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [SH_W_P-1:0]  next_shift_i,
  output logic [SH_W_P-1:0]  act_shift_o,
  output logic [CNT_W_P-1:0] cnt_o,
  output logic               en_o
);
  logic [SH_W_P-1:0]  act_q;
  logic [CNT_W_P-1:0] cnt_q;
  logic [CNT_W_P-1:0] limit;
  logic               wrap;
  logic               en_q;

  assign limit = {CNT_W_P{1'b1}} >> (CNT_W_P - int'(act_q));
  assign wrap  = tick_i && (cnt_q == limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else begin
      en_q <= wrap;
      if (wrap) begin
        cnt_q <= '0;
        act_q <= next_shift_i;  // ratio swap only at period end
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign act_shift_o = act_q;
  assign cnt_o       = cnt_q;
  assign en_o        = en_q;
endmodule

// File: rtl/onehot_clkdiv.sv
module onehot_clkdiv
  import clkdiv_pkg::*;
#(
  parameter int unsigned DIV_W_P  = DIV_W,
  parameter int unsigned REG_W_P  = REG_W,
  parameter int unsigned TEST_B_P = TEST_B
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               src_sel_i,
  input  logic               pll_tick_i,
  input  logic               ext_tick_i,
  input  logic               wr_en_i,
  input  logic [REG_W_P-1:0] wr_data_i,
  output logic [REG_W_P-1:0] rd_data_o,
  output logic               en_o
);
  localparam int unsigned SH_L  = $clog2(DIV_W_P);
  localparam int unsigned CNT_L = (DIV_W_P > 1) ? DIV_W_P - 1 : 1;

  logic [DIV_W_P-1:0] div_field;
  logic [SH_L-1:0]    next_shift;
  logic [SH_L-1:0]    act_shift;
  logic [CNT_L-1:0]   cnt;
  logic               sel_tick;

  assign sel_tick = src_sel_i ? ext_tick_i : pll_tick_i;

  clkdiv_ctrl_reg #(
    .REG_W_P (REG_W_P),
    .DIV_W_P (DIV_W_P),
    .TEST_B_P(TEST_B_P)
  ) reg_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .div_field_o(div_field),
    .rd_data_o  (rd_data_o)
  );

  clkdiv_ratio_dec #(
    .DIV_W_P(DIV_W_P),
    .SH_W_P (SH_L)
  ) dec_i (
    .div_field_i(div_field),
    .shift_o    (next_shift)
  );

  clkdiv_tick_gen #(
    .SH_W_P (SH_L),
    .CNT_W_P(CNT_L)
  ) gen_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (sel_tick),
    .next_shift_i(next_shift),
    .act_shift_o (act_shift),
    .cnt_o       (cnt),
    .en_o        (en_o)
  );
endmodule

// File: rtl/onehot_clkdiv_chk.sv
module onehot_clkdiv_chk #(
  parameter int unsigned REG_W_P  = 32,
  parameter int unsigned DIV_W_P  = 16,
  parameter int unsigned TEST_B_P = 31,
  parameter int unsigned SH_L     = 4,
  parameter int unsigned CNT_L    = 15
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               src_sel_i,
  input logic               pll_tick_i,
  input logic               ext_tick_i,
  input logic               wr_en_i,
  input logic [REG_W_P-1:0] wr_data_i,
  input logic [REG_W_P-1:0] rd_data_o,
  input logic               en_o,
  input logic [SH_L-1:0]    act_shift,
  input logic [CNT_L-1:0]   cnt
);
  logic [REG_W_P-1:0] keep_mask;
  always_comb begin
    keep_mask = '0;
    keep_mask[DIV_W_P-1:0] = '1;
    keep_mask[TEST_B_P]    = 1'b1;
  end

  assert_pulse_from_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_o |-> $past(src_sel_i ? ext_tick_i : pll_tick_i));

  assert_bypass_every_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((src_sel_i ? ext_tick_i : pll_tick_i) && act_shift == '0) |=> en_o);

  assert_readback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o == ($past(wr_data_i) & keep_mask)));

  assert_reserved_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o & ~keep_mask) == '0);

  assert_swap_at_boundary_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_shift) |-> en_o);

  assert_cnt_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt) < (32'd1 << act_shift));
endmodule

bind onehot_clkdiv onehot_clkdiv_chk #(
  .REG_W_P (REG_W_P),
  .DIV_W_P (DIV_W_P),
  .TEST_B_P(TEST_B_P),
  .SH_L    (SH_L),
  .CNT_L   (CNT_L)
) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .src_sel_i (src_sel_i),
  .pll_tick_i(pll_tick_i),
  .ext_tick_i(ext_tick_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .en_o      (en_o),
  .act_shift (act_shift),
  .cnt       (cnt)
);

// File: tb/onehot_clkdiv_tb_top.sv
`timescale 1ns/1ps
module onehot_clkdiv_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        src_sel_i = 1'b0;
  logic        pll_tick_i = 1'b0;
  logic        ext_tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        en_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;  // 125 MHz

  onehot_clkdiv dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_sel_i(src_sel_i),
    .pll_tick_i(pll_tick_i), .ext_tick_i(ext_tick_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .en_o(en_o)
  );

  task automatic check(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic write_word(logic [31:0] v);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_data_i = v;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_pulse();
    do @(negedge clk_i); while (!en_o);
  endtask

  // cycles from the current pulse to the next
  task automatic gap(output int d);
    d = 0;
    do begin @(negedge clk_i); d++; end while (!en_o);
  endtask

  task automatic ratio_test(string req, logic [31:0] v, int exp_gap);
    int d;
    write_word(v);
    wait_pulse(); wait_pulse(); wait_pulse();
    gap(d);
    check(req, d, exp_gap);
  endtask

  task automatic t_reset();
    check("R1 readback after reset", rd_data_o, 0);
    pll_tick_i = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      check("R1 pass-through after reset", en_o, 1);
    end
  endtask

  task automatic t_bypass_pattern();
    logic prev;
    write_word(32'h0);
    wait_pulse();
    prev = pll_tick_i;
    for (int i = 0; i < 12; i++) begin
      pll_tick_i = (i % 3) != 1;
      @(negedge clk_i);
      check("R2 bypass follows tick", en_o, pll_tick_i ? 1 : 0);
    end
    pll_tick_i = 1'b1;
  endtask

  task automatic t_source_select();
    src_sel_i = 1'b1;
    for (int i = 0; i < 10; i++) begin
      pll_tick_i = i[0];
      ext_tick_i = ~i[0] & i[1];
      @(negedge clk_i);
      check("R5 ext source counted, pll ignored", en_o, ext_tick_i ? 1 : 0);
    end
    src_sel_i = 1'b0;
    for (int i = 0; i < 10; i++) begin
      pll_tick_i = i[1];
      ext_tick_i = ~i[1];
      @(negedge clk_i);
      check("R5 pll source counted, ext ignored", en_o, pll_tick_i ? 1 : 0);
    end
    pll_tick_i = 1'b1; ext_tick_i = 1'b0;
  endtask

  task automatic t_sparse();
    int d;
    write_word(32'h0000_0004);  // divide by 4
    pll_tick_i = 1'b0;
    fork
      begin
        while (!done) begin @(negedge clk_i); pll_tick_i = ~pll_tick_i; end
      end
      begin
        wait_pulse(); wait_pulse(); wait_pulse();
        gap(d);
        check("R3 divide 4 with tick every other cycle", d, 8);
        done = 1'b1;
      end
    join
    done = 1'b0;
    pll_tick_i = 1'b1;
  endtask

  task automatic t_swap();
    int d;
    ratio_test("R3 divide by 8", 32'h0000_0008, 8);
    repeat (3) @(negedge clk_i);
    write_word(32'h0000_0002);
    d = 3 + 2;
    do begin @(negedge clk_i); d++; end while (!en_o);
    check("R6 pulse after write keeps old spacing", d, 8);
    gap(d);
    check("R6 new spacing after boundary", d, 2);
  endtask

  task automatic t_readback();
    write_word(32'hFFFF_FFFF);
    check("R7 reserved bits read zero", rd_data_o, 32'h8000_FFFF);
    wait_pulse(); wait_pulse();
    begin
      int d; gap(d);
      check("R7 test bit no effect, lowest bit ratio", d, 1);
    end
    write_word(32'h8000_0010);
    check("R7 test bit readback", rd_data_o, 32'h8000_0010);
    write_word(32'h0001_0000);
    check("R7 bit 16 dropped", rd_data_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_bypass_pattern();
    t_source_select();
    ratio_test("R3 divide by 2", 32'h0000_0002, 2);
    ratio_test("R3 divide by 16", 32'h0000_0010, 16);
    ratio_test("R4 lowest of bits 2 and 4", 32'h0000_0014, 4);
    ratio_test("R4 lowest of bits 7 and 15", 32'h0000_8080, 128);
    t_sparse();
    t_swap();
    t_readback();
    ratio_test("R3 divide by 32768", 32'h0000_8000, 32768);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule